// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a memory shared by two ports, A and B, and turns the two highest addresses of that memory into mailboxes for messaging between the ports. Each clock cycle it samples, for each port, an access enable, a write strobe and an address. It does not hold or return any data. It only decides, from those accesses, whether each port has a message waiting.

The highest address is the mailbox owned by port B, and the address just below it is the mailbox owned by port A. When one port writes into the mailbox of the other port, an active-low interrupt goes to the owner of that mailbox. The interrupt stays low until the owner reads its own mailbox. The storage behind the mailboxes, semaphores and address-collision arbitration live elsewhere in the chip. The address width is a parameter.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `a_irq_n` and `b_irq_n` are high (no message pending).
- R2: Port A writes to address all-ones (enable=1, write=1) in a cycle. From the next cycle on, `b_irq_n` is low.
- R3: Port B writes to address all-ones minus one (enable=1, write=1) in a cycle. From the next cycle on, `a_irq_n` is low.
- R4: A read (enable=1, write=0) by port B at address all-ones returns `b_irq_n` high in the next cycle. A read by port A at address all-ones minus one returns `a_irq_n` high in the next cycle.
- R5: A port writing into its own mailbox (A at all-ones minus one, B at all-ones) does not change its own interrupt.
- R6: If a setting write and a clearing read of the same interrupt fall in the same cycle, the interrupt is low in the next cycle.
- R7: The following leave both interrupts unchanged: accesses with enable low, accesses to any other address, and a read of the other port's mailbox.
- R8: Several setting writes before a clearing read leave exactly one pending message, so a single owner read releases the interrupt.
- R9: Each interrupt output changes only in the cycle after the access that causes the change, and is otherwise stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A access valid this cycle |
| a_we | input | 1 | Port A access is a write (1) or a read (0) |
| a_addr | input | AW | Port A address |
| b_en | input | 1 | Port B access valid this cycle |
| b_we | input | 1 | Port B access is a write (1) or a read (0) |
| b_addr | input | AW | Port B address |
| a_irq_n | output | 1 | Active-low message-pending flag for port A |
| b_irq_n | output | 1 | Active-low message-pending flag for port B |

## Verification
Each interrupt is a direct copy of one stored pending bit. A wrong internal state therefore shows up on the matching interrupt pin in the cycle after the access that caused it. That wrong value stays visible until a later clearing read or setting write overwrites it. The bench compares both pins against its own model after every sampled cycle. A wrongly routed, mis-decoded or mis-prioritised event is therefore caught within one cycle of the access that exposes it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPORT = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  // The port that sits on the other side of a given port.
  function automatic int peer_of(input int p);
    return (p == PORT_A) ? PORT_B : PORT_A;
  endfunction

  // How far below the all-ones address a port's mailbox lies.
  function automatic int box_offset(input int p);
    return (p == PORT_B) ? 0 : 1;
  endfunction

  // Next value of a pending bit; a setting event takes priority over a clearing one.
  function automatic logic next_pending(input logic cur, input logic set_ev,
                                        input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int AW = 12
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic [mbx_pkg::NPORT-1:0] wr_hit_o,
  output logic [mbx_pkg::NPORT-1:0] rd_hit_o
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  function automatic logic [AW-1:0] box_addr(input int p);
    return TOP_ADDR - AW'(box_offset(p));
  endfunction

  logic [NPORT-1:0] match;

  for (genvar p = 0; p < NPORT; p++) begin : g_box
    assign match[p]    = (addr_i == box_addr(p));
    assign wr_hit_o[p] = en_i & we_i & match[p];
    assign rd_hit_o[p] = en_i & ~we_i & match[p];
  end
endmodule

// File: rtl/mbx_pending_flag.sv
module mbx_pending_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  import mbx_pkg::*;

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_pending(pend_q, set_i, clr_i);
  end

  assign irq_n_o = ~pend_q;

  // R2 / R3 / R6: a setting event always leaves the flag pending
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n_o);
  // R4: a lone clearing read releases the interrupt
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n_o);
  // R9: without an event the output holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  output logic          a_irq_n,
  output logic          b_irq_n
);
  import mbx_pkg::*;

  logic          en   [NPORT];
  logic          we   [NPORT];
  logic [AW-1:0] addr [NPORT];
  logic [NPORT-1:0] wr_hit [NPORT];
  logic [NPORT-1:0] rd_hit [NPORT];
  logic [NPORT-1:0] set_ev;
  logic [NPORT-1:0] clr_ev;
  logic [NPORT-1:0] own_wr;
  logic [NPORT-1:0] irq_n;

  assign en[PORT_A]   = a_en;
  assign we[PORT_A]   = a_we;
  assign addr[PORT_A] = a_addr;
  assign en[PORT_B]   = b_en;
  assign we[PORT_B]   = b_we;
  assign addr[PORT_B] = b_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode #(.AW(AW)) u_dec (
      .en_i    (en[p]),
      .we_i    (we[p]),
      .addr_i  (addr[p]),
      .wr_hit_o(wr_hit[p]),
      .rd_hit_o(rd_hit[p])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_flag
    // set: the peer writes into this port's mailbox; clear: owner reads it
    assign set_ev[p] = wr_hit[peer_of(p)][p];
    assign clr_ev[p] = rd_hit[p][p];
    assign own_wr[p] = wr_hit[p][p];

    mbx_pending_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_ev[p]),
      .clr_i  (clr_ev[p]),
      .irq_n_o(irq_n[p])
    );
  end

  assign a_irq_n = irq_n[PORT_A];
  assign b_irq_n = irq_n[PORT_B];

  // R2: port A writing the top address raises B's interrupt
  assert_cross_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && a_addr == {AW{1'b1}}) |=> !b_irq_n);
  // R3: port B writing the next address raises A's interrupt
  assert_cross_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we && b_addr == {AW{1'b1}} - AW'(1)) |=> !a_irq_n);
  // R5: an own-mailbox write alone never pulls its own interrupt low
  assert_own_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr[PORT_A] && !set_ev[PORT_A] && a_irq_n) |=> a_irq_n);
  assert_own_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr[PORT_B] && !set_ev[PORT_B] && b_irq_n) |=> b_irq_n);
  // R7: an interrupt only falls after the peer wrote the owner's mailbox
  assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_irq_n) |-> $past(b_en && b_we));
endmodule

// File: tb/mbx_irq_top_bench.sv
module mbx_irq_top_bench;
  localparam int AW = 12;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = {AW{1'b1}} - AW'(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_irq_n, b_irq_n;
  logic exp_a = 1'b0, exp_b = 1'b0;   // expected pending bits
  int checks = 0, errors = 0;
  int unused_seed;

  always #2 clk = ~clk;

  mbx_irq_top #(.AW(AW)) u_mbx_irq_top (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  // pending bit model written from the requirements
  function automatic logic model_next(input logic cur, input logic set_ev, input logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic ae, input logic aw, input logic [AW-1:0] aa,
                      input logic be, input logic bw, input logic [AW-1:0] ba);
    logic sa, ca, sb, cb;
    @(negedge clk);
    a_en = ae; a_we = aw; a_addr = aa;
    b_en = be; b_we = bw; b_addr = ba;
    sb = ae && aw && aa == TOP;
    sa = be && bw && ba == NEXT;
    ca = ae && !aw && aa == NEXT;
    cb = be && !bw && ba == TOP;
    @(posedge clk);
    exp_a = model_next(exp_a, sa, ca);
    exp_b = model_next(exp_b, sb, cb);
    #1;
    check(req, "a_irq_n", a_irq_n, ~exp_a);
    check(req, "b_irq_n", b_irq_n, ~exp_b);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, '0, 0, 0, '0);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int r = $urandom % 4;
    if (r == 0) return TOP;
    if (r == 1) return NEXT;
    return AW'($urandom);
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    check("R1", "a_irq_n in reset", a_irq_n, 1'b1);
    check("R1", "b_irq_n in reset", b_irq_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    idle("R1");

    // R2: A writes B's mailbox, R4: B reads to clear
    step("R2", 1, 1, TOP, 0, 0, '0);
    idle("R9");
    step("R4", 0, 0, '0, 1, 0, TOP);
    // R3 and clear by A
    step("R3", 0, 0, '0, 1, 1, NEXT);
    step("R4", 1, 0, NEXT, 0, 0, '0);
    // R5: own-mailbox writes
    step("R5", 1, 1, NEXT, 1, 1, TOP);
    // R7: disabled, other addresses, peer-mailbox reads
    step("R7", 0, 1, TOP, 0, 1, NEXT);
    step("R7", 1, 1, 12'h123, 1, 1, 12'h000);
    step("R7", 1, 0, TOP, 1, 0, NEXT);
    // R8: repeated sets then one clear
    step("R8", 1, 1, TOP, 1, 1, NEXT);
    step("R8", 1, 1, TOP, 1, 1, NEXT);
    step("R8", 1, 1, TOP, 1, 1, NEXT);
    step("R8", 1, 0, NEXT, 1, 0, TOP);
    idle("R8");
    // R6: set and clear in the same cycle, both ports
    step("R6", 1, 1, TOP, 1, 0, TOP);
    step("R6", 1, 0, NEXT, 1, 1, NEXT);
    step("R4", 1, 0, NEXT, 1, 0, TOP);

    for (int i = 0; i < 3000; i++)
      step("R9", $urandom % 4 != 0, $urandom % 2 == 1, pick_addr(),
           $urandom % 4 != 0, $urandom % 2 == 1, pick_addr());

    // mid-run reset returns both flags high
    step("R2", 1, 1, TOP, 1, 1, NEXT);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    exp_a = 1'b0; exp_b = 1'b0;
    check("R1", "a_irq_n after reset", a_irq_n, 1'b1);
    check("R1", "b_irq_n after reset", b_irq_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule